// File: doc/BRIEF.md
# Multipath Packet Spray Selector with Path Health Tracking

This block picks the network path for each outgoing packet of one transport connection in a multipath NIC. The connection owns a fixed set of paths, each named by an entropy value that the fabric uses to steer the packet. Every send request gets its own path choice, so a single connection's traffic is spread packet by packet across the whole set rather than pinned to one hashed route.

Each path carries a two-bit health state. Returning feedback for a path arrives as one of three events: a plain acknowledgement, an acknowledgement carrying a congestion (ECN) mark, or a timeout. The block collects these events over a round-trip epoch. When the epoch tick arrives it re-grades every path at once. Paths graded unhealthy leave the rotation from the next selection onward. A path that has been declared dead stays out until the control side clears it with a per-path reset.

The selector walks the table round-robin. It prefers healthy paths and falls back to congested ones only when no healthy path is left. When nothing is usable it refuses the request and raises a flag, rather than repeat an old entropy value.

Top module: `pspray_top`

## Requirements
- R1: After reset every path is healthy (code 00), `sel_valid` and `all_down` are low, and the first selection returns path 0.
- R2: Each send request picks the next healthy path after the previously chosen one, in ascending index order, wrapping from the last index to 0.
- R3: At an epoch tick, a healthy path whose epoch saw at least one acknowledgement, some ECN-marked acknowledgement and no timeout becomes congested (code 01) and is not chosen while any healthy path exists.
- R4: Congested paths are chosen, round-robin, only when no path is healthy.
- R5: At an epoch tick, a path whose epoch saw a timeout or no acknowledgement at all becomes suspect (code 10) and is never chosen. An epoch with acknowledgements, no ECN mark and no timeout returns a congested or suspect path to healthy. An epoch with acknowledgements and ECN marks but no timeout makes a suspect path congested.
- R6: A suspect path with a second bad epoch in a row becomes dead (code 11). A dead path ignores all later epochs and is never chosen until `path_rst` with its index returns it to healthy.
- R7: With no healthy or congested path, `all_down` is high, and a send request yields `sel_valid` low in the next cycle with no path or entropy value offered.
- R8: A send request in cycle t drives `sel_valid`, `sel_path` and `sel_ev` in cycle t+1. The choice uses the health states held in cycle t, so an update made at the same edge takes effect from the following request onward.
- R9: The entropy value of path p is (EV_BASE + p * EV_STRIDE) modulo 2^EV_W.
- R10: Feedback presented in the cycle of an epoch tick counts toward the epoch being closed. A per-path reset in the same cycle as a tick wins for that path and discards its epoch record. Feedback kind code 3 is ignored (kinds: 0 acknowledgement, 1 ECN-marked acknowledgement, 2 timeout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| send_req | input | 1 | Request a path for one outgoing packet |
| fb_valid | input | 1 | A feedback event is present |
| fb_path | input | IDX_W | Path the feedback belongs to |
| fb_kind | input | 2 | 0 ack, 1 ECN-marked ack, 2 timeout, 3 ignored |
| epoch_tick | input | 1 | Close the current round-trip epoch and re-grade all paths |
| path_rst | input | 1 | Return one path to healthy |
| path_rst_idx | input | IDX_W | Path cleared by `path_rst` |
| sel_valid | output | 1 | A path was chosen for last cycle's request |
| sel_path | output | IDX_W | Chosen path index |
| sel_ev | output | EV_W | Entropy value of the chosen path |
| all_down | output | 1 | No healthy or congested path remains |

## Verification
The bench builds the block with an eight-entry table, a 12-bit entropy value, a base of 3968 and a stride of 37. Eight paths let an epoch's worth of random feedback leave a real mix of healthy, congested, suspect and dead paths, so round-robin wraparound, congested-only fallback and the all-down state all occur within a few dozen cycles. The base and stride make the entropy sum overflow 12 bits at the upper indices, which exercises the modulo rule. Directed epochs place feedback, ticks, resets and requests in the same cycle to pin down the ordering rules.

// File: rtl/pspray_pkg.sv
package pspray_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'b00,
    PH_CONG   = 2'b01,
    PH_SUSP   = 2'b10,
    PH_DEAD   = 2'b11
  } path_health_e;

  localparam logic [1:0] FB_ACK     = 2'd0;
  localparam logic [1:0] FB_ACK_ECN = 2'd1;
  localparam logic [1:0] FB_TIMEOUT = 2'd2;

endpackage

// File: rtl/pspray_health_cell.sv
module pspray_health_cell
  import pspray_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic [1:0]   kind,
  input  logic         tick,
  input  logic         clr,
  output path_health_e health
);

  path_health_e st_q, st_d;
  logic ack_q, ecn_q, to_q;
  logic ack_d, ecn_d, to_d;
  logic ack_c, ecn_c, to_c, bad, en;

  always_comb begin
    ack_c = ack_q | (hit & ((kind == FB_ACK) | (kind == FB_ACK_ECN)));
    ecn_c = ecn_q | (hit & (kind == FB_ACK_ECN));
    to_c  = to_q  | (hit & (kind == FB_TIMEOUT));
    bad   = to_c | ~ack_c;
    en    = hit | tick | clr;
    st_d  = st_q;
    ack_d = ack_c;
    ecn_d = ecn_c;
    to_d  = to_c;
    if (clr) begin
      st_d  = PH_ACTIVE;
      ack_d = 1'b0;
      ecn_d = 1'b0;
      to_d  = 1'b0;
    end else if (tick) begin
      ack_d = 1'b0;
      ecn_d = 1'b0;
      to_d  = 1'b0;
      if (st_q != PH_DEAD) begin
        if (bad) st_d = (st_q == PH_SUSP) ? PH_DEAD : PH_SUSP;
        else if (ecn_c) st_d = PH_CONG;
        else st_d = PH_ACTIVE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_ACTIVE;
      ack_q <= 1'b0;
      ecn_q <= 1'b0;
      to_q  <= 1'b0;
    end else if (en) begin
      st_q  <= st_d;
      ack_q <= ack_d;
      ecn_q <= ecn_d;
      to_q  <= to_d;
    end
  end

  assign health = st_q;

  // R6
  dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_DEAD && !clr) |=> (st_q == PH_DEAD));

  // R10
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(st_q));

  // R5
  no_direct_death_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_ACTIVE) |=> (st_q != PH_DEAD));

endmodule

// File: rtl/pspray_rr_pick.sv
module pspray_rr_pick #(
  parameter int unsigned N     = 128,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] ptr,
  output logic             found,
  output logic [IDX_W-1:0] pick
);

  logic [N-1:0] above;
  logic         hi_found;
  logic [IDX_W-1:0] hi_pick, lo_pick;

  always_comb begin
    for (int i = 0; i < N; i++) above[i] = req[i] && (i > int'(ptr));
    hi_found = |above;
    hi_pick  = '0;
    lo_pick  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (above[i]) hi_pick = IDX_W'(i);
      if (req[i])   lo_pick = IDX_W'(i);
    end
    found = |req;
    pick  = hi_found ? hi_pick : lo_pick;
  end

endmodule

// File: rtl/pspray_top.sv
module pspray_top
  import pspray_pkg::*;
#(
  parameter int unsigned NUM_PATHS = 128,
  parameter int unsigned EV_W      = 16,
  parameter int unsigned EV_BASE   = 32'h0000_4000,
  parameter int unsigned EV_STRIDE = 32'h0000_0101,
  localparam int unsigned IDX_W    = $clog2(NUM_PATHS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_req,
  input  logic             fb_valid,
  input  logic [IDX_W-1:0] fb_path,
  input  logic [1:0]       fb_kind,
  input  logic             epoch_tick,
  input  logic             path_rst,
  input  logic [IDX_W-1:0] path_rst_idx,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_path,
  output logic [EV_W-1:0]  sel_ev,
  output logic             all_down
);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  path_health_e     health [NUM_PATHS];
  logic [NUM_PATHS-1:0] act_vec, cong_vec;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    pspray_health_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .hit    (fb_valid && (fb_path == IDX_W'(g))),
      .kind   (fb_kind),
      .tick   (epoch_tick),
      .clr    (path_rst && (path_rst_idx == IDX_W'(g))),
      .health (health[g])
    );
    assign act_vec[g]  = (health[g] == PH_ACTIVE);
    assign cong_vec[g] = (health[g] == PH_CONG);
  end

  logic [IDX_W-1:0] ptr_q, act_pick, cong_pick, pick;
  logic             act_found, cong_found, any_found;

  pspray_rr_pick #(.N(NUM_PATHS), .IDX_W(IDX_W)) u_pick_act (
    .req(act_vec), .ptr(ptr_q), .found(act_found), .pick(act_pick));

  pspray_rr_pick #(.N(NUM_PATHS), .IDX_W(IDX_W)) u_pick_cong (
    .req(cong_vec), .ptr(ptr_q), .found(cong_found), .pick(cong_pick));

  logic [31:0]      ev_full;
  logic             sel_valid_q, sel_valid_d, out_en;
  logic [IDX_W-1:0] sel_path_q, ptr_d;
  logic [EV_W-1:0]  sel_ev_q, sel_ev_d;

  always_comb begin
    any_found   = act_found | cong_found;
    pick        = act_found ? act_pick : cong_pick;
    ev_full     = EV_BASE + 32'(pick) * EV_STRIDE;
    sel_ev_d    = ev_full[EV_W-1:0];
    sel_valid_d = send_req & any_found;
    out_en      = send_req & any_found;
    ptr_d       = pick;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sel_valid_q <= 1'b0;
    else          sel_valid_q <= sel_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ptr_q      <= IDX_W'(NUM_PATHS - 1);
      sel_path_q <= '0;
      sel_ev_q   <= '0;
    end else if (out_en) begin
      ptr_q      <= ptr_d;
      sel_path_q <= pick;
      sel_ev_q   <= sel_ev_d;
    end
  end

  assign sel_valid = sel_valid_q;
  assign sel_path  = sel_path_q;
  assign sel_ev    = sel_ev_q;
  assign all_down  = ~(|act_vec | |cong_vec);

  // R8
  grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (send_req && !all_down) |=> sel_valid);

  // R7
  no_stale_ev_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (send_req && all_down) |=> !sel_valid);

  // R8
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !send_req |=> !sel_valid);

  // R2
  path_held_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !send_req |=> $stable(sel_path));

endmodule

// File: tb/pspray_top_bench.sv
module pspray_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 8;
  localparam int IW     = 3;
  localparam int EVW    = 12;
  localparam int EVBASE = 3968;
  localparam int EVSTEP = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send_req = 0, fb_valid = 0, epoch_tick = 0, path_rst = 0;
  logic [IW-1:0] fb_path = '0, path_rst_idx = '0;
  logic [1:0] fb_kind = '0;
  logic sel_valid, all_down;
  logic [IW-1:0] sel_path;
  logic [EVW-1:0] sel_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pspray_top #(.NUM_PATHS(N), .EV_W(EVW), .EV_BASE(EVBASE), .EV_STRIDE(EVSTEP)) u_pspray_top (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .fb_valid(fb_valid),
    .fb_path(fb_path), .fb_kind(fb_kind), .epoch_tick(epoch_tick),
    .path_rst(path_rst), .path_rst_idx(path_rst_idx), .sel_valid(sel_valid),
    .sel_path(sel_path), .sel_ev(sel_ev), .all_down(all_down));

  int vectors = 0, fails = 0;
  int mst [N];
  bit mack [N], mecn [N], mto [N];
  int mptr;

  function automatic int ev_of(int p);
    return (EVBASE + p * EVSTEP) % (1 << EVW);
  endfunction

  function automatic int model_pick();
    for (int j = 1; j <= N; j++) if (mst[(mptr + j) % N] == 0) return (mptr + j) % N;
    for (int j = 1; j <= N; j++) if (mst[(mptr + j) % N] == 1) return (mptr + j) % N;
    return -1;
  endfunction

  function automatic bit model_down();
    for (int p = 0; p < N; p++) if (mst[p] < 2) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < N; p++) begin mst[p] = 0; mack[p] = 0; mecn[p] = 0; mto[p] = 0; end
    mptr = N - 1;
  endtask

  task automatic model_update(bit s, bit fv, int fp, int fk, bit tk, bit pr, int pi, int pk);
    if (s && pk >= 0) mptr = pk;
    for (int p = 0; p < N; p++) begin
      bit a, e, t;
      a = mack[p] || (fv && fp == p && (fk == 0 || fk == 1));
      e = mecn[p] || (fv && fp == p && fk == 1);
      t = mto[p]  || (fv && fp == p && fk == 2);
      if (pr && pi == p) begin
        mst[p] = 0; a = 0; e = 0; t = 0;
      end else if (tk) begin
        if (mst[p] != 3) begin
          if (t || !a) mst[p] = (mst[p] == 2) ? 3 : 2;
          else if (e) mst[p] = 1;
          else mst[p] = 0;
        end
        a = 0; e = 0; t = 0;
      end
      mack[p] = a; mecn[p] = e; mto[p] = t;
    end
  endtask

  task automatic step(bit s, bit fv, int fp, int fk, bit tk, bit pr, int pi, string tag);
    int pk;
    bit ok;
    @(negedge clk);
    send_req = s; fb_valid = fv; fb_path = IW'(fp); fb_kind = 2'(fk);
    epoch_tick = tk; path_rst = pr; path_rst_idx = IW'(pi);
    pk = model_pick();
    @(posedge clk);
    model_update(s, fv, fp, fk, tk, pr, pi, pk);
    #1;
    vectors++;
    ok = 1;
    if (sel_valid !== (s && pk >= 0)) ok = 0;
    if (s && pk >= 0 && (sel_path !== IW'(pk) || sel_ev !== EVW'(ev_of(pk)))) ok = 0;
    if (all_down !== model_down()) ok = 0;
    if (!ok) begin
      fails++;
      $display("FAIL %s: valid/path/ev/down = %0b/%0d/%0d/%0b expected %0b/%0d/%0d/%0b",
               tag, sel_valid, sel_path, sel_ev, all_down,
               (s && pk >= 0), pk, (pk >= 0) ? ev_of(pk) : 0, model_down());
    end
  endtask

  task automatic sends(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fb(int p, int k, string tag);
    step(0, 1, p, k, 0, 0, 0, tag);
  endtask

  task automatic tick(string tag);
    step(0, 0, 0, 0, 1, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, then first pick is path 0
    @(negedge clk); #1;
    vectors++;
    if (sel_valid !== 1'b0 || all_down !== 1'b0) begin
      fails++;
      $display("FAIL R1: valid/down = %0b/%0b expected 0/0", sel_valid, all_down);
    end
    step(1, 0, 0, 0, 0, 0, 0, "R1 first pick");

    // R2 R9: round robin with wraparound, entropy value with modulo
    sends(10, "R2 R9 rotation");

    // R3: path 2 sees only ECN-marked acks
    for (int p = 0; p < N; p++) fb(p, (p == 2) ? 1 : 0, "R3 feedback");
    tick("R3 tick");
    sends(9, "R3 congested skipped");

    // R4: every path congested
    for (int p = 0; p < N; p++) fb(p, 1, "R4 feedback");
    tick("R4 tick");
    sends(10, "R4 congested rotation");

    // R5: paths 4..7 silent, become suspect
    for (int p = 0; p < 4; p++) fb(p, 0, "R5 feedback");
    tick("R5 tick");
    sends(6, "R5 suspect skipped");
    fb(5, 1, "R5 feedback");
    for (int p = 0; p < N; p++) if (p != 5) fb(p, 0, "R5 feedback");
    tick("R5 recover");
    sends(9, "R5 recovered");

    // R10 R8: timeout on path 5 together with tick and a send request
    for (int p = 0; p < N; p++) if (p != 5) fb(p, 0, "R10 feedback");
    fb(5, 0, "R10 feedback");
    sends(4, "R8 advance");
    step(1, 1, 5, 2, 1, 0, 0, "R8 R10 same-cycle");
    sends(8, "R10 timeout counted");

    // R6: second bad epoch kills path 5; clean epoch does not revive it
    for (int p = 0; p < N; p++) if (p != 5) fb(p, 0, "R6 feedback");
    tick("R6 tick dead");
    for (int p = 0; p < N; p++) fb(p, 0, "R6 feedback");
    fb(5, 3, "R10 ignored kind");
    tick("R6 clean epoch");
    sends(9, "R6 dead skipped");
    step(0, 0, 0, 0, 0, 1, 5, "R6 path reset");
    sends(9, "R6 revived");

    // R7: silent epochs take everything down
    tick("R7 tick");
    sends(2, "R7 suspect all");
    tick("R7 tick");
    sends(2, "R7 all down");
    // R10: reset and tick together, reset wins for path 0
    step(1, 1, 0, 2, 1, 1, 0, "R10 reset beats tick");
    sends(3, "R10 only path 0");
    for (int p = 1; p < N; p++) step(0, 0, 0, 0, 0, 1, p, "R6 reset all");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) < 6, ($urandom % 10) < 8, $urandom % N, $urandom % 4,
           ($urandom % 12) == 0, ($urandom % 10) == 0, $urandom % N,
           "R2 R3 R4 R5 R6 R7 R8 random");
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule